// File: doc/BRIEF.md
# Reloading Global Interrupt Timer

This block is a programmable down-counter that produces an interrupt request each time it runs out. It then reloads itself from a stored base count and keeps running. Software controls it through a 32-bit register port. Writing the base count register starts or stops the timer: the top bit of the written value is a halt flag. While halted, the remaining count is frozen and can be read back unchanged.

Each request carries the timer's own priority, vector and destination set. These come from a source configuration register and a destination register that belong to the timer. The sense and polarity fields of the source register are fixed to edge and positive by hardware. A separate frequency reporting register is a plain read/write word that software uses to record the tick rate. Choosing between several requesters is left to a downstream arbiter.

The counter moves only on cycles where the tick enable input is high. The rate of `tick_i` therefore sets the time base.

Top module: `reload_timer`

## Requirements
- R1: After reset the base count reads 0x8000_0000 (halted), the current count reads 0, the source register reads 0x8080_0000 (masked), the destination reads 0, the frequency register reads 1, and `irq_o` is low.
- R2: A write to the base count (offset 0x10) with bit 31 clear while halted loads the current count with bits 30:0 of the value and starts the timer.
- R3: While running, the current count (offset 0x00) drops by one on each cycle with `tick_i` high and holds on cycles without it. Bit 31 of the current count reads 0.
- R4: When a tick arrives while running with a current count of 1 or 0, the timer expires. It reloads bits 30:0 of the stored base and pulses `irq_o` for one cycle, so a base of N gives one request every N ticks.
- R5: A base count write with bit 31 set while running stops the timer. The current count freezes, and later ticks leave it unchanged.
- R6: A base count write that leaves the halt state unchanged stores the new base and leaves the current count untouched. A running timer uses the new base at its next reload.
- R7: The source register (offset 0x20) keeps the mask (bit 31), priority (bits 19:16) and vector (bits 7:0). Bit 23 always reads 1, bit 22 always reads 0, and all other bits read 0. The priority and vector appear on `irq_prio_o` and `irq_vec_o`.
- R8: While the mask bit is set, expiries still reload the count but `irq_o` stays low.
- R9: The destination register (offset 0x30) stores only its low DEST_W bits, and drives `irq_dest_o`.
- R10: The frequency register (offset 0x40) stores and returns a full 32-bit value.
- R11: Reads from offsets outside the five registers return 0, and writes to them change no register.
- R12: A base count write in the same cycle as a tick takes effect, and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | One-cycle interrupt request on expiry |
| irq_prio_o | output | 4 | Request priority |
| irq_vec_o | output | 8 | Request vector |
| irq_dest_o | output | DEST_W | Request destination set |

## Verification
The bench targets expiry at a count of one. A design that is off by one there would stretch or shorten the period, and the bench catches it through the cycle in which `irq_o` fires.

A write that halts the timer must not reload the count. A design that gets this wrong reads back the base instead of the frozen value.

A base write that leaves the halt state unchanged must not disturb a running count. A design that restarts on every write reads the new base right away.

A tick in the same cycle as a write must be dropped. A design that honours both moves the frozen count. The bench also writes the forced sense and polarity bits to the opposite values, and writes an unmapped offset and then reads back its neighbours.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = DATA_W - 1;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned VEC_W  = 8;

  // register byte offsets inside the timer block
  localparam logic [ADDR_W-1:0] OFS_CUR  = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_BASE = 7'h10;
  localparam logic [ADDR_W-1:0] OFS_SRC  = 7'h20;
  localparam logic [ADDR_W-1:0] OFS_DEST = 7'h30;
  localparam logic [ADDR_W-1:0] OFS_FREQ = 7'h40;

  // source register field positions
  localparam int unsigned SRC_MASK_BIT = 31;
  localparam int unsigned SRC_POL_BIT  = 23;
  localparam int unsigned SRC_LVL_BIT  = 22;
  localparam int unsigned SRC_PRIO_LSB = 16;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CUR, SEL_BASE, SEL_SRC, SEL_DEST, SEL_FREQ
  } reg_sel_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              base_wr_i,
  input  logic [DATA_W-1:0] base_wdata_i,
  output logic [DATA_W-1:0] base_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              expire_o
);
  logic [DATA_W-1:0] base_q;
  logic [CNT_W-1:0]  count_q;
  logic              expire_q;
  logic              halted;

  assign halted = base_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= {1'b1, {CNT_W{1'b0}}};
      count_q  <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (base_wr_i) begin
        // write wins over a coincident tick
        base_q <= base_wdata_i;
        if (halted && !base_wdata_i[DATA_W-1])
          count_q <= base_wdata_i[CNT_W-1:0];
      end else if (!halted && tick_i) begin
        if (count_q <= CNT_W'(1)) begin
          count_q  <= base_q[CNT_W-1:0];
          expire_q <= 1'b1;
        end else begin
          count_q <= count_q - CNT_W'(1);
        end
      end
    end
  end

  assign base_o   = base_q;
  assign count_o  = count_q;
  assign expire_o = expire_q;

  assert_expire_when_run_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> $past(!halted && tick_i && !base_wr_i));
  assert_reload_on_expire_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_q |-> count_q == base_q[CNT_W-1:0]);
  assert_frozen_when_halted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |=> (!halted || $stable(count_q)));
  assert_decrement_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halted && tick_i && !base_wr_i && count_q > CNT_W'(1)) |=>
      count_q == $past(count_q) - CNT_W'(1));
  assert_hold_no_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !base_wr_i) |=> $stable(count_q));
endmodule

// File: rtl/tmr_src_cfg.sv
module tmr_src_cfg
  import timer_pkg::*;
#(
  parameter int unsigned DEST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_wr_i,
  input  logic              dest_wr_i,
  input  logic              freq_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dest_o,
  output logic [DATA_W-1:0] freq_o,
  output logic              mask_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [DEST_W-1:0] dest_set_o
);
  logic              mask_q;
  logic [PRIO_W-1:0] prio_q;
  logic [VEC_W-1:0]  vec_q;
  logic [DEST_W-1:0] dest_q;
  logic [DATA_W-1:0] freq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b1;
      prio_q <= '0;
      vec_q  <= '0;
      dest_q <= '0;
      freq_q <= DATA_W'(1);
    end else begin
      if (src_wr_i) begin
        mask_q <= wdata_i[SRC_MASK_BIT];
        prio_q <= wdata_i[SRC_PRIO_LSB +: PRIO_W];
        vec_q  <= wdata_i[VEC_W-1:0];
      end
      if (dest_wr_i) dest_q <= wdata_i[DEST_W-1:0];
      if (freq_wr_i) freq_q <= wdata_i;
    end
  end

  // sense is fixed to edge, polarity to positive
  always_comb begin
    src_o = '0;
    src_o[SRC_MASK_BIT] = mask_q;
    src_o[SRC_POL_BIT]  = 1'b1;
    src_o[SRC_LVL_BIT]  = 1'b0;
    src_o[SRC_PRIO_LSB +: PRIO_W] = prio_q;
    src_o[VEC_W-1:0] = vec_q;
  end

  assign dest_o     = DATA_W'(dest_q);
  assign freq_o     = freq_q;
  assign mask_o     = mask_q;
  assign prio_o     = prio_q;
  assign vec_o      = vec_q;
  assign dest_set_o = dest_q;

  assert_src_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_wr_i |=> (prio_o == $past(wdata_i[SRC_PRIO_LSB +: PRIO_W])
                  && vec_o == $past(wdata_i[VEC_W-1:0])));
  assert_freq_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freq_wr_i |=> $stable(freq_o));
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int unsigned DEST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [6:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic [3:0]        irq_prio_o,
  output logic [7:0]        irq_vec_o,
  output logic [DEST_W-1:0] irq_dest_o
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] base_rd, src_rd, dest_rd, freq_rd;
  logic [CNT_W-1:0]  count;
  logic              expire, mask;

  always_comb begin
    unique case (addr_i)
      OFS_CUR:  sel = SEL_CUR;
      OFS_BASE: sel = SEL_BASE;
      OFS_SRC:  sel = SEL_SRC;
      OFS_DEST: sel = SEL_DEST;
      OFS_FREQ: sel = SEL_FREQ;
      default:  sel = SEL_NONE;
    endcase
  end

  tmr_counter u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .base_wr_i    (wr_i && sel == SEL_BASE),
    .base_wdata_i (wdata_i),
    .base_o       (base_rd),
    .count_o      (count),
    .expire_o     (expire)
  );

  tmr_src_cfg #(.DEST_W(DEST_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_wr_i   (wr_i && sel == SEL_SRC),
    .dest_wr_i  (wr_i && sel == SEL_DEST),
    .freq_wr_i  (wr_i && sel == SEL_FREQ),
    .wdata_i    (wdata_i),
    .src_o      (src_rd),
    .dest_o     (dest_rd),
    .freq_o     (freq_rd),
    .mask_o     (mask),
    .prio_o     (irq_prio_o),
    .vec_o      (irq_vec_o),
    .dest_set_o (irq_dest_o)
  );

  always_comb begin
    unique case (sel)
      SEL_CUR:  rdata_o = {1'b0, count};
      SEL_BASE: rdata_o = base_rd;
      SEL_SRC:  rdata_o = src_rd;
      SEL_DEST: rdata_o = dest_rd;
      SEL_FREQ: rdata_o = freq_rd;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = expire && !mask;

  assert_irq_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o || $past(tick_i));
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask && $stable(mask)) |-> !irq_o);
  assert_unmapped_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel == SEL_NONE |-> rdata_o == '0);
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  localparam int DEST_W = 4;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  req;
    logic [6:0]  addr;
    logic [31:0] data;
  } step_t;

  localparam int NSTEP = 27;
  localparam step_t STEPS [NSTEP] = '{
    '{OP_WR, 4'd7,  7'h20, 32'h0045_0012},  // R7 write opposite sense/polarity
    '{OP_RD, 4'd7,  7'h20, 32'h0085_0012},
    '{OP_WR, 4'd9,  7'h30, 32'hFFFF_FFFF},  // R9
    '{OP_RD, 4'd9,  7'h30, 32'h0000_000F},
    '{OP_WR, 4'd10, 7'h40, 32'h1234_5678},  // R10
    '{OP_RD, 4'd10, 7'h40, 32'h1234_5678},
    '{OP_WR, 4'd2,  7'h10, 32'h0000_0005},  // R2 start
    '{OP_RD, 4'd2,  7'h10, 32'h0000_0005},
    '{OP_RD, 4'd2,  7'h00, 32'h0000_0005},
    '{OP_TK, 4'd3,  7'h00, 32'h0},          // R3
    '{OP_TK, 4'd3,  7'h00, 32'h0},
    '{OP_RD, 4'd3,  7'h00, 32'h0000_0003},
    '{OP_WR, 4'd5,  7'h10, 32'h8000_0000},  // R5 stop
    '{OP_RD, 4'd5,  7'h00, 32'h0000_0003},
    '{OP_RD, 4'd5,  7'h10, 32'h8000_0000},
    '{OP_TK, 4'd5,  7'h00, 32'h0},
    '{OP_RD, 4'd5,  7'h00, 32'h0000_0003},
    '{OP_WR, 4'd6,  7'h10, 32'h8000_0009},  // R6 halted, halt unchanged
    '{OP_RD, 4'd6,  7'h00, 32'h0000_0003},
    '{OP_RD, 4'd6,  7'h10, 32'h8000_0009},
    '{OP_WR, 4'd11, 7'h50, 32'h0000_DEAD},  // R11 unmapped
    '{OP_RD, 4'd11, 7'h50, 32'h0000_0000},
    '{OP_RD, 4'd11, 7'h40, 32'h1234_5678},
    '{OP_RD, 4'd11, 7'h10, 32'h8000_0009},
    '{OP_RD, 4'd11, 7'h20, 32'h0085_0012},
    '{OP_WR, 4'd2,  7'h10, 32'h0000_0002},  // R2 restart
    '{OP_RD, 4'd2,  7'h00, 32'h0000_0002}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, wr = 1'b0;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  logic [3:0] prio;
  logic [7:0] vec;
  logic [DEST_W-1:0] dest;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  reload_timer #(.DEST_W(DEST_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_prio_o(prio),
    .irq_vec_o(vec), .irq_dest_o(dest)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d; tick = tk;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  // pulses tick for one cycle; irq is sampled right after the counting edge
  task automatic tick_once(output logic irq_seen);
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1; irq_seen = irq;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    logic seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd_chk("R1 base", 7'h10, 32'h8000_0000);
    rd_chk("R1 count", 7'h00, 32'h0);
    rd_chk("R1 src", 7'h20, 32'h0080_0000 | 32'h8000_0000);
    rd_chk("R1 dest", 7'h30, 32'h0);
    rd_chk("R1 freq", 7'h40, 32'h1);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      case (STEPS[i].op)
        OP_WR: wr_reg(STEPS[i].addr, STEPS[i].data);
        OP_TK: tick_once(seen);
        default: rd_chk($sformatf("R%0d step %0d", STEPS[i].req, i),
                        STEPS[i].addr, STEPS[i].data);
      endcase
    end

    // R4: base 2 running, count 2; expires on the second tick
    tick_once(seen); check("R4 no early irq", {31'b0, seen}, 32'h0);
    tick_once(seen); check("R4 irq on expiry", {31'b0, seen}, 32'h1);
    check("R7 irq prio", {28'b0, prio}, 32'h5);
    check("R7 irq vec", {24'b0, vec}, 32'h12);
    check("R9 irq dest", {28'b0, dest}, 32'hF);
    rd_chk("R4 reload", 7'h00, 32'h2);
    check("R4 single pulse", {31'b0, irq}, 32'h0);

    // R8 masked: reload continues, no request
    wr_reg(7'h20, 32'h8000_0012);
    tick_once(seen); tick_once(seen);
    check("R8 masked irq", {31'b0, seen}, 32'h0);
    rd_chk("R8 reload", 7'h00, 32'h2);
    wr_reg(7'h20, 32'h0005_0012);

    // R6 running base change leaves count, used at next reload
    wr_reg(7'h10, 32'h0000_0004);
    rd_chk("R6 count kept", 7'h00, 32'h2);
    tick_once(seen);
    rd_chk("R6 count dec", 7'h00, 32'h1);
    tick_once(seen);
    check("R6 irq", {31'b0, seen}, 32'h1);
    rd_chk("R6 new base reload", 7'h00, 32'h4);

    // R12 stop write with coincident tick: tick dropped
    wr_reg(7'h10, 32'h8000_0000, 1'b1);
    rd_chk("R12 frozen", 7'h00, 32'h4);
    // R12 start write with coincident tick: count is the new base
    wr_reg(7'h10, 32'h0000_0003, 1'b1);
    rd_chk("R12 start", 7'h00, 32'h3);
    // R3 no tick holds
    repeat (4) @(negedge clk);
    rd_chk("R3 hold", 7'h00, 32'h3);

    // R4 period of three ticks
    tick_once(seen); check("R4 p1", {31'b0, seen}, 32'h0);
    tick_once(seen); check("R4 p2", {31'b0, seen}, 32'h0);
    tick_once(seen); check("R4 p3", {31'b0, seen}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule